// File: doc/BRIEF.md
# Single-Cycle Load/Store Processor Core

This block is a 32-bit processor that finishes one instruction in every clock cycle. A program counter addresses a small instruction store. The fetched word is decoded into a set of steering controls. Two register operands are read, and one shared ALU does three jobs: arithmetic, forming memory addresses and comparing for branches. On the next rising edge the result goes back to the register file, to the data store or to the program counter.

Nine operations are recognised: word load and word store, five register-to-register operations (add, subtract, AND, OR, signed set-less-than), branch-if-equal and an unconditional jump. Any other encoding does nothing, and the PC steps past it. Both memories are internal word arrays. They are filled through a load port while the core is held in reset. The core's progress is observed on a debug view that shows the current PC and the register write made by the instruction at that PC.

Top module: `lsc_core`

## Requirements
- R1: While reset (`rst_n` low) is asserted, the PC is 0 and all 31 writable registers hold 0. The first instruction after release is fetched from byte address 0.
- R2: When no taken branch or jump applies, the next PC is the current PC plus 4. The instruction word is taken from word index PC[7:2] of the instruction store.
- R3: R-type instructions have opcode bits[31:26]=0x00, rs=[25:21], rt=[20:16], rd=[15:11] and funct=[5:0]. Funct 0x20 adds, 0x22 subtracts (rs-rt), 0x24 ANDs and 0x25 ORs. The result is written to rd.
- R4: Funct 0x2A writes 1 to rd when rs is less than rt as signed two's-complement values, and 0 otherwise.
- R5: Load (opcode 0x23) writes to rt the data word at address rs + sign-extended imm[15:0]. The word index is address bits [7:2], and address bits [1:0] are ignored.
- R6: Store (opcode 0x2B) writes rt to the data word at rs + sign-extended imm[15:0], indexed as in R5. It makes no register write.
- R7: Branch-if-equal (opcode 0x04) compares rs and rt. When they are equal, the next PC is PC+4 plus the sign-extended imm[15:0] shifted left by 2. When they differ, the next PC is PC+4.
- R8: Jump (opcode 0x02) sets the next PC to PC+4 bits [31:28] followed by instr[25:0] and two zero bits.
- R9: Register 0 always reads as 0. A write that names register 0 leaves it at 0.
- R10: Any other opcode, and an R-type word with any other funct, writes no register and no memory, and the PC advances by 4.
- R11: `dbg_wr_en`, `dbg_wr_addr` and `dbg_wr_data` show, in the same cycle, the register write of the instruction at `dbg_pc`. That write takes effect at the next rising edge.
- R12: With `ld_en` high, `ld_data` is written on the rising edge to word `ld_addr` of the data store when `ld_dmem` is 1, and of the instruction store when `ld_dmem` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_en | input | 1 | Memory preload write strobe |
| ld_dmem | input | 1 | Preload target: 1 data store, 0 instruction store |
| ld_addr | input | 6 | Preload word index |
| ld_data | input | 32 | Preload word |
| dbg_pc | output | 32 | Address of the instruction executing this cycle |
| dbg_wr_en | output | 1 | Instruction at dbg_pc writes a register |
| dbg_wr_addr | output | 5 | Destination register of that write |
| dbg_wr_data | output | 32 | Value of that write |

## Verification
The debug write signals depend combinationally on the PC register, so they are due in the same cycle that `dbg_pc` shows the instruction. The new PC, the register contents and any stored word are due one rising edge later. The bench waits 1 ns after each falling edge and then compares the PC and the write signals against a behavioural model, which it advances by one instruction per comparison. A register or memory effect is therefore seen in the following cycle, as the operand value of a later instruction or as the data it loads.

// File: rtl/lsc_pkg.sv
package lsc_pkg;

  localparam int XLEN = 32;
  localparam int RA_W = 5;

  typedef enum logic [2:0] {
    ALU_AND = 3'b000,
    ALU_OR  = 3'b001,
    ALU_ADD = 3'b010,
    ALU_SUB = 3'b110,
    ALU_SLT = 3'b111
  } alu_op_e;

  localparam logic [5:0] OPC_RTYPE = 6'h00;
  localparam logic [5:0] OPC_LOAD  = 6'h23;
  localparam logic [5:0] OPC_STORE = 6'h2B;
  localparam logic [5:0] OPC_BEQ   = 6'h04;
  localparam logic [5:0] OPC_JUMP  = 6'h02;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef struct packed {
    logic    reg_we;
    logic    dst_rd;
    logic    src_imm;
    logic    mem_re;
    logic    mem_we;
    logic    wb_mem;
    logic    branch;
    logic    jump;
    logic    illegal;
    alu_op_e alu_op;
  } ctl_t;

  function automatic logic [XLEN-1:0] sext16(input logic [15:0] v);
    return {{(XLEN-16){v[15]}}, v};
  endfunction

  function automatic logic [XLEN-1:0] alu_eval(input alu_op_e op,
                                               input logic [XLEN-1:0] a,
                                               input logic [XLEN-1:0] b);
    logic [XLEN-1:0] y;
    case (op)
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_ADD: y = a + b;
      ALU_SUB: y = a - b;
      ALU_SLT: y = {{(XLEN-1){1'b0}}, ($signed(a) < $signed(b))};
      default: y = '0;
    endcase
    return y;
  endfunction

  function automatic logic [XLEN-1:0] branch_target(input logic [XLEN-1:0] pc4,
                                                    input logic [15:0] off);
    return pc4 + (sext16(off) << 2);
  endfunction

  function automatic logic [XLEN-1:0] jump_target(input logic [XLEN-1:0] pc4,
                                                  input logic [25:0] idx);
    return {pc4[XLEN-1:XLEN-4], idx, 2'b00};
  endfunction

endpackage

// File: rtl/lsc_alu.sv
module lsc_alu
  import lsc_pkg::*;
#(
  parameter int W = XLEN
) (
  input  alu_op_e        op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [W-1:0]   y,
  output logic           zero
);

  always_comb begin
    y    = alu_eval(op, a, b);
    zero = (y == '0);
  end

endmodule

// File: rtl/lsc_ctrl.sv
module lsc_ctrl
  import lsc_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctl_t       ctl
);

  always_comb begin
    ctl        = '0;
    ctl.alu_op = ALU_ADD;
    case (opcode)
      OPC_RTYPE: begin
        ctl.reg_we = 1'b1;
        ctl.dst_rd = 1'b1;
        case (funct)
          FN_ADD:  ctl.alu_op = ALU_ADD;
          FN_SUB:  ctl.alu_op = ALU_SUB;
          FN_AND:  ctl.alu_op = ALU_AND;
          FN_OR:   ctl.alu_op = ALU_OR;
          FN_SLT:  ctl.alu_op = ALU_SLT;
          default: begin
            ctl.reg_we  = 1'b0;
            ctl.dst_rd  = 1'b0;
            ctl.illegal = 1'b1;
          end
        endcase
      end
      OPC_LOAD: begin
        ctl.reg_we  = 1'b1;
        ctl.src_imm = 1'b1;
        ctl.mem_re  = 1'b1;
        ctl.wb_mem  = 1'b1;
      end
      OPC_STORE: begin
        ctl.src_imm = 1'b1;
        ctl.mem_we  = 1'b1;
      end
      OPC_BEQ: begin
        ctl.branch = 1'b1;
        ctl.alu_op = ALU_SUB;
      end
      OPC_JUMP: begin
        ctl.jump = 1'b1;
      end
      default: ctl.illegal = 1'b1;
    endcase
  end

endmodule

// File: rtl/lsc_regfile.sv
module lsc_regfile
  import lsc_pkg::*;
#(
  parameter int NREGS = 32,
  parameter int W     = XLEN,
  localparam int AW   = $clog2(NREGS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] ra1,
  input  logic [AW-1:0] ra2,
  output logic [W-1:0]  rd1,
  output logic [W-1:0]  rd2,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd
);

  logic [W-1:0] regs_q [1:NREGS-1];

  // One flop row per writable register; register 0 has no storage.
  for (genvar g = 1; g < NREGS; g++) begin : g_row
    logic sel;
    assign sel = we && (wa == AW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   regs_q[g] <= '0;
      else if (sel) regs_q[g] <= wd;
    end
  end

  always_comb begin
    rd1 = (ra1 == '0) ? '0 : regs_q[ra1];
    rd2 = (ra2 == '0) ? '0 : regs_q[ra2];
  end

endmodule

// File: rtl/lsc_core.sv
module lsc_core
  import lsc_pkg::*;
#(
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64,
  parameter int LD_AW = (IMEM_WORDS > DMEM_WORDS) ? $clog2(IMEM_WORDS) : $clog2(DMEM_WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_en,
  input  logic             ld_dmem,
  input  logic [LD_AW-1:0] ld_addr,
  input  logic [31:0]      ld_data,
  output logic [31:0]      dbg_pc,
  output logic             dbg_wr_en,
  output logic [4:0]       dbg_wr_addr,
  output logic [31:0]      dbg_wr_data
);

  localparam int IA_W = $clog2(IMEM_WORDS);
  localparam int DA_W = $clog2(DMEM_WORDS);

  logic [XLEN-1:0] imem_mem [IMEM_WORDS];
  logic [XLEN-1:0] dmem_mem [DMEM_WORDS];

  logic [XLEN-1:0] pc_q, pc_next, pc_plus4;
  logic [XLEN-1:0] instr;
  logic [5:0]      opcode, funct;
  logic [RA_W-1:0] rs, rt, rd, wr_addr;
  logic [15:0]     imm;
  logic [25:0]     jidx;
  ctl_t            ctl;
  logic [XLEN-1:0] rf_rd1, rf_rd2, alu_b, alu_y, dm_rdata, wb_data;
  logic            alu_zero;
  logic [DA_W-1:0] dm_idx;
  // Named events for the checker.
  logic            br_taken, jmp_sel, st_en, illegal;

  // Fetch
  assign pc_plus4 = pc_q + 32'd4;
  assign instr    = imem_mem[pc_q[IA_W+1:2]];

  assign opcode = instr[31:26];
  assign rs     = instr[25:21];
  assign rt     = instr[20:16];
  assign rd     = instr[15:11];
  assign funct  = instr[5:0];
  assign imm    = instr[15:0];
  assign jidx   = instr[25:0];

  lsc_ctrl u_ctrl (
    .opcode (opcode),
    .funct  (funct),
    .ctl    (ctl)
  );

  lsc_regfile #(.NREGS(32), .W(XLEN)) u_rf (
    .clk   (clk),
    .rst_n (rst_n),
    .ra1   (rs),
    .ra2   (rt),
    .rd1   (rf_rd1),
    .rd2   (rf_rd2),
    .we    (ctl.reg_we),
    .wa    (wr_addr),
    .wd    (wb_data)
  );

  // Operand select (ALUSrc equivalent)
  assign alu_b = ctl.src_imm ? sext16(imm) : rf_rd2;

  lsc_alu #(.W(XLEN)) u_alu (
    .op   (ctl.alu_op),
    .a    (rf_rd1),
    .b    (alu_b),
    .y    (alu_y),
    .zero (alu_zero)
  );

  // Data store access
  assign dm_idx   = alu_y[DA_W+1:2];
  assign dm_rdata = ctl.mem_re ? dmem_mem[dm_idx] : '0;
  assign st_en    = ctl.mem_we && rst_n;

  // Write-back select
  assign wb_data = ctl.wb_mem ? dm_rdata : alu_y;
  assign wr_addr = ctl.dst_rd ? rd : rt;

  // Next PC select
  assign br_taken = ctl.branch && alu_zero;
  assign jmp_sel  = ctl.jump;
  assign illegal  = ctl.illegal;

  always_comb begin
    if (jmp_sel)       pc_next = jump_target(pc_plus4, jidx);
    else if (br_taken) pc_next = branch_target(pc_plus4, imm);
    else               pc_next = pc_plus4;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_next;
  end

  always_ff @(posedge clk) begin
    if (ld_en && !ld_dmem) imem_mem[ld_addr[IA_W-1:0]] <= ld_data;
  end

  always_ff @(posedge clk) begin
    if (ld_en && ld_dmem) dmem_mem[ld_addr[DA_W-1:0]] <= ld_data;
    else if (st_en)       dmem_mem[dm_idx] <= rf_rd2;
  end

  assign dbg_pc      = pc_q;
  assign dbg_wr_en   = ctl.reg_we;
  assign dbg_wr_addr = wr_addr;
  assign dbg_wr_data = wb_data;

endmodule

// File: rtl/lsc_core_chk.sv
module lsc_core_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] dbg_pc,
  input logic        dbg_wr_en,
  input logic [31:0] pc_plus4,
  input logic [31:0] instr,
  input logic        br_taken,
  input logic        jmp_sel,
  input logic        st_en,
  input logic        illegal,
  input logic [4:0]  rs,
  input logic [31:0] rf_rd1
);

  p_pc_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> dbg_pc == 32'd0);

  p_pc_seq_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!br_taken && !jmp_sel) |=> dbg_pc == $past(dbg_pc) + 32'd4);

  p_store_nowr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    st_en |-> !dbg_wr_en);

  p_branch_r7: assert property (@(posedge clk) disable iff (!rst_n)
    br_taken |=> dbg_pc == $past(pc_plus4) + {{14{$past(instr[15])}}, $past(instr[15:0]), 2'b00});

  p_jump_r8: assert property (@(posedge clk) disable iff (!rst_n)
    jmp_sel |=> dbg_pc == {$past(pc_plus4[31:28]), $past(instr[25:0]), 2'b00});

  p_zero_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rs == 5'd0) |-> rf_rd1 == 32'd0);

  p_nop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (!dbg_wr_en && !st_en && !br_taken && !jmp_sel));

endmodule

bind lsc_core lsc_core_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .dbg_pc    (dbg_pc),
  .dbg_wr_en (dbg_wr_en),
  .pc_plus4  (pc_plus4),
  .instr     (instr),
  .br_taken  (br_taken),
  .jmp_sel   (jmp_sel),
  .st_en     (st_en),
  .illegal   (illegal),
  .rs        (rs),
  .rf_rd1    (rf_rd1)
);

// File: tb/lsc_core_tb.sv
`timescale 1ns/1ps
module lsc_core_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_en = 1'b0;
  logic        ld_dmem = 1'b0;
  logic [5:0]  ld_addr = '0;
  logic [31:0] ld_data = '0;
  logic [31:0] dbg_pc, dbg_wr_data;
  logic        dbg_wr_en;
  logic [4:0]  dbg_wr_addr;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  lsc_core dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .ld_en       (ld_en),
    .ld_dmem     (ld_dmem),
    .ld_addr     (ld_addr),
    .ld_data     (ld_data),
    .dbg_pc      (dbg_pc),
    .dbg_wr_en   (dbg_wr_en),
    .dbg_wr_addr (dbg_wr_addr),
    .dbg_wr_data (dbg_wr_data)
  );

  // Reference state
  logic [31:0] m_imem [64];
  logic [31:0] m_dmem [64];
  logic [31:0] m_reg  [32];
  logic [31:0] m_pc;
  string       pc_tag;

  function automatic logic [31:0] enc_r(int s, int t, int d, logic [5:0] fn);
    return {6'h00, 5'(s), 5'(t), 5'(d), 5'd0, fn};
  endfunction
  function automatic logic [31:0] enc_i(logic [5:0] op, int s, int t, int off);
    return {op, 5'(s), 5'(t), 16'(off)};
  endfunction
  function automatic logic [31:0] enc_j(logic [5:0] op, int idx);
    return {op, 26'(idx)};
  endfunction

  task automatic check(string req, string what, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // Compare this cycle, then advance the model by one instruction.
  task automatic model_step();
    logic [31:0] ins, a, b, res, addr, npc;
    logic [5:0]  op, fn;
    logic [4:0]  s, t, d;
    logic [15:0] off;
    logic        we, st;
    logic [4:0]  wa;
    string       tag, ntag;
    ins = m_imem[(m_pc >> 2) % 64];
    op = ins[31:26]; s = ins[25:21]; t = ins[20:16]; d = ins[15:11];
    fn = ins[5:0]; off = ins[15:0];
    a = m_reg[s]; b = m_reg[t];
    we = 1'b0; st = 1'b0; wa = '0; res = '0;
    npc = m_pc + 32'd4; ntag = "R2"; tag = "R10";
    if (op == 6'h00) begin
      we = 1'b1; wa = d; tag = "R3";
      if (fn == 6'h20) res = a + b;
      else if (fn == 6'h22) res = a - b;
      else if (fn == 6'h24) res = a & b;
      else if (fn == 6'h25) res = a | b;
      else if (fn == 6'h2A) begin res = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0; tag = "R4"; end
      else begin we = 1'b0; tag = "R10"; ntag = "R10"; end
      if (we && (s == 0 || t == 0 || d == 0)) tag = "R9";
    end else if (op == 6'h23) begin
      addr = a + {{16{off[15]}}, off};
      we = 1'b1; wa = t; res = m_dmem[(addr >> 2) % 64]; tag = "R5";
    end else if (op == 6'h2B) begin
      st = 1'b1; tag = "R6";
    end else if (op == 6'h04) begin
      tag = "R7"; ntag = "R7";
      if (a == b) npc = m_pc + 32'd4 + {{14{off[15]}}, off, 2'b00};
    end else if (op == 6'h02) begin
      tag = "R8"; ntag = "R8";
      npc = {npc[31:28], ins[25:0], 2'b00};
    end else begin
      ntag = "R10";
    end
    if (m_pc == 0) tag = "R1";
    check(pc_tag, "pc", dbg_pc, m_pc);
    check(tag, "R11 wr_en", {31'd0, dbg_wr_en}, {31'd0, we});
    if (we) begin
      check(tag, "wr_addr", {27'd0, dbg_wr_addr}, {27'd0, wa});
      check(tag, "wr_data", dbg_wr_data, res);
    end
    if (we && wa != 0) m_reg[wa] = res;
    if (st) begin
      addr = a + {{16{off[15]}}, off};
      m_dmem[(addr >> 2) % 64] = b;
    end
    m_pc = npc;
    pc_tag = ntag;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 64; i++) begin m_imem[i] = '0; m_dmem[i] = '0; end
    for (int i = 0; i < 32; i++) m_reg[i] = '0;
    m_dmem[0] = 32'h1234_5678;
    m_dmem[1] = 32'hFFFF_FFF0;
    m_dmem[2] = 32'd7;
    m_dmem[4] = 32'hCAFE_F00D;
    m_imem[0]  = enc_r(20, 21, 15, 6'h20);     // regs zero after reset (R1)
    m_imem[1]  = enc_i(6'h23, 0, 1, 0);
    m_imem[2]  = enc_i(6'h23, 0, 2, 4);
    m_imem[3]  = enc_i(6'h23, 0, 3, 8);
    m_imem[4]  = enc_r(1, 3, 4, 6'h20);
    m_imem[5]  = enc_r(3, 2, 5, 6'h22);
    m_imem[6]  = enc_r(1, 2, 6, 6'h24);
    m_imem[7]  = enc_r(1, 3, 7, 6'h25);
    m_imem[8]  = enc_r(2, 3, 8, 6'h2A);        // -16 < 7 signed (R4)
    m_imem[9]  = enc_r(3, 2, 9, 6'h2A);
    m_imem[10] = enc_r(1, 1, 0, 6'h20);        // write to r0 (R9)
    m_imem[11] = enc_r(0, 3, 10, 6'h20);
    m_imem[12] = enc_i(6'h2B, 0, 5, 12);       // store (R6)
    m_imem[13] = enc_i(6'h23, 0, 11, 12);
    m_imem[14] = enc_i(6'h08, 1, 12, 5);       // unknown opcode (R10)
    m_imem[15] = enc_r(1, 1, 12, 6'h00);       // unknown funct (R10)
    m_imem[16] = enc_i(6'h04, 3, 2, 5);        // not taken (R7)
    m_imem[17] = enc_i(6'h04, 3, 10, 2);       // taken to word 20 (R7)
    m_imem[18] = enc_r(1, 1, 12, 6'h20);
    m_imem[19] = enc_r(1, 1, 12, 6'h20);
    m_imem[20] = enc_i(6'h2B, 5, 4, -8);       // address 15: low bits ignored (R5)
    m_imem[21] = enc_i(6'h23, 0, 13, 12);
    m_imem[22] = enc_i(6'h23, 0, 14, 16);
    m_imem[23] = enc_j(6'h02, 26);             // jump (R8)
    m_imem[24] = enc_r(1, 1, 12, 6'h20);
    m_imem[25] = enc_r(1, 1, 12, 6'h20);
    m_imem[26] = enc_i(6'h04, 0, 0, -1);       // branch to itself

    // R12: preload both stores while in reset
    for (int i = 0; i < 128; i++) begin
      @(negedge clk);
      ld_en = 1'b1; ld_dmem = (i >= 64); ld_addr = 6'(i % 64);
      ld_data = (i >= 64) ? m_dmem[i - 64] : m_imem[i];
    end
    @(negedge clk);
    ld_en = 1'b0;
    #1;
    check("R1", "pc in reset", dbg_pc, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    m_pc = '0;
    pc_tag = "R1";
    #1;
    for (int c = 0; c < 40; c++) begin
      model_step();
      @(negedge clk);
      #1;
    end
    finish_run();
  end

endmodule